// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves a byte-wide word between two ports, A and B, through two independent storage stages, one for each direction. Each stage has its own three active-low controls. The first is a direction enable, which gates both capture and drive. The second is a capture control; while it is low the stage is transparent, and when it rises the stage holds its value. The third is a drive control, which lets the stored or transparent word out onto the opposite port. Data passes through without inversion.

Each port has a separate input bus, output bus and drive flag, so the block needs no tri-state cells. Storage is a clocked register. The value seen at the output is taken straight from the source while capture is open, so the output behaves like a transparent latch without inferring one. A synchronous active-low reset clears both stages.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While `rst_n` is low, both drive flags are 0. A clock edge with `rst_n` low clears both stored words to zero. After release, a latched stage shows 8'h00.
- R2: With a direction's enable high, its drive flag is 0 and its stored word does not change at a clock edge, whatever its capture and drive controls and its source port carry.
- R3: With enable low and capture low, the stage is transparent. The opposite port's data equals the source port in the same cycle, and the source is stored at the clock edge.
- R4: When capture rises with enable low, the stage keeps the word stored at the last edge on which capture was low.
- R5: With enable low and capture high, later changes on the source port do not reach the output.
- R6: With the drive control high, that direction's drive flag is 0.
- R7: A drive flag is 1 exactly when reset is released and both enable and drive control are low. Its data is then the current stage word, not inverted.
- R8: The B-to-A stage obeys R2 to R7 with its own controls. The controls of either direction never change the other direction's flag or word.
- R9: Whenever a drive flag is 0, its output data bus is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | Word presented on port A |
| b_in | input | 8 | Word presented on port B |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B capture control, active low (low = transparent) |
| ab_oe_n | input | 1 | A-to-B drive control, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A capture control, active low (low = transparent) |
| ba_oe_n | input | 1 | B-to-A drive control, active low |
| a_out | output | 8 | Word driven onto port A by the B-to-A stage |
| a_oe | output | 1 | Port A is being driven by the block |
| b_out | output | 8 | Word driven onto port B by the A-to-B stage |
| b_oe | output | 1 | Port B is being driven by the block |

## Verification
The assertions check three things on every cycle: a stage changes its word only on a capture cycle or a reset cycle, a capture edge stores the source, and a drive flag never rises unless its enable and drive control are both low and never leaves data on an idle bus. Some behaviour shows only across a sequence of cycles, and the bench's scenarios cover it. A word captured while its output was hidden must come out later. A rising capture control must freeze the last transparent word. One direction's activity must leave the other untouched. Each scenario walks every row of the control table for both directions.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the latched bus transceiver.
// Assumes: a single byte-wide data path in both directions.
package xcvr_pkg;
    localparam int XCVR_W    = 8;
    localparam int XCVR_DIRS = 2;
    localparam int DIR_AB    = 0;
    localparam int DIR_BA    = 1;
endpackage

// File: rtl/xcvr_store.sv
// One direction's storage stage. It behaves like a level-sensitive latch
// built from a clocked register: while capture is open, the visible word is
// the source itself and the register follows it on each edge. Otherwise the
// register holds.
// Assumes: controls are synchronous to clk; rst_n is synchronous, active low.
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic         le_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] view
);
    logic         open_w;
    logic [W-1:0] held_q;

    // Capture window: enable and capture control both low.
    always_comb open_w = ~en_n & ~le_n;

    // Visible word: the source while open, otherwise the held word.
    always_comb view = open_w ? src : held_q;

    // Storage register: cleared by reset, loaded while open.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (open_w) held_q <= src;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> held_q == '0);
    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !le_n) |=> held_q == $past(src));
    // R5
    hold_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && le_n) |=> $stable(held_q));
    // R2
    hold_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(held_q));
endmodule

// File: rtl/xcvr_gate.sv
// One direction's output gate. It drives the stage word onto the opposite
// port when enable and drive control are both low. An idle bus is forced to
// zero and the drive flag is held low during reset.
// Assumes: view is the stage word from xcvr_store.
module xcvr_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic         oe_n,
    input  logic [W-1:0] view,
    output logic         drive,
    output logic [W-1:0] dout
);
    // Drive decision: reset released, enable low, drive control low.
    always_comb drive = rst_n & ~en_n & ~oe_n;

    // Output bus: the stage word when driving, zero when idle.
    always_comb dout = drive ? view : '0;

    // R7
    drive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (!en_n && !oe_n));
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> dout == '0);
    // R6
    oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive);
endmodule

// File: rtl/bidir_latch_xcvr.sv
// Top level: two mirrored stage-plus-gate paths. Path 0 carries A to B and
// path 1 carries B to A. Each path has its own enable, capture and drive
// controls, all active low.
// Assumes: the environment does not drive a port while its flag is high.
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_en_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_en_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [XCVR_DIRS-1:0] en_v, le_v, oe_v, drv_v;
    logic [W-1:0]         src_v  [XCVR_DIRS];
    logic [W-1:0]         view_v [XCVR_DIRS];
    logic [W-1:0]         dat_v  [XCVR_DIRS];

    // Route per-direction controls and sources into indexed vectors.
    always_comb begin
        en_v[DIR_AB]  = ab_en_n;  en_v[DIR_BA] = ba_en_n;
        le_v[DIR_AB]  = ab_le_n;  le_v[DIR_BA] = ba_le_n;
        oe_v[DIR_AB]  = ab_oe_n;  oe_v[DIR_BA] = ba_oe_n;
        src_v[DIR_AB] = a_in;     src_v[DIR_BA] = b_in;
    end

    for (genvar d = 0; d < XCVR_DIRS; d++) begin : g_path
        xcvr_store #(.W(W)) u_store (
            .clk(clk), .rst_n(rst_n), .en_n(en_v[d]), .le_n(le_v[d]),
            .src(src_v[d]), .view(view_v[d])
        );
        xcvr_gate #(.W(W)) u_gate (
            .clk(clk), .rst_n(rst_n), .en_n(en_v[d]), .oe_n(oe_v[d]),
            .view(view_v[d]), .drive(drv_v[d]), .dout(dat_v[d])
        );
    end

    // Map path outputs to the opposite port of each direction.
    always_comb begin
        b_out = dat_v[DIR_AB];
        b_oe  = drv_v[DIR_AB];
        a_out = dat_v[DIR_BA];
        a_oe  = drv_v[DIR_BA];
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!a_oe && !b_oe));
endmodule

// File: tb/bidir_latch_xcvr_bench.sv
// Bench: walks a table of control rows for each direction, then runs
// directed reset and independence tests.
module bidir_latch_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic       ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic       ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe;
    int         n_cmp = 0, n_bad = 0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    bidir_latch_xcvr u_bidir_latch_xcvr (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // Row: {en_n, le_n, oe_n, source word, expected flag, expected data}
    localparam logic [19:0] ROWS [12] = '{
        {3'b000, 8'h3C, 1'b1, 8'h3C},  // R3 transparent
        {3'b000, 8'hA5, 1'b1, 8'hA5},  // R3 follows source
        {3'b010, 8'h5A, 1'b1, 8'hA5},  // R4 capture rise keeps A5
        {3'b011, 8'hFF, 1'b0, 8'h00},  // R6 drive off, R9 zero
        {3'b100, 8'h11, 1'b0, 8'h00},  // R2 disabled, no capture
        {3'b111, 8'h22, 1'b0, 8'h00},  // R2
        {3'b010, 8'h33, 1'b1, 8'hA5},  // R2 R5 still A5
        {3'b001, 8'hC3, 1'b0, 8'h00},  // R3 hidden capture
        {3'b010, 8'h00, 1'b1, 8'hC3},  // R4 R7 hidden word shows
        {3'b101, 8'h77, 1'b0, 8'h00},  // R2
        {3'b010, 8'h01, 1'b1, 8'hC3},  // R5
        {3'b000, 8'h80, 1'b1, 8'h80}   // R7 non-inverted
    };

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual flag/data %b/%h expected %b/%h",
                     tag, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    // Apply one row to direction dir, hold the other direction disabled.
    task automatic run_row(input int dir, input logic [19:0] r, input int idx);
        @(negedge clk);
        if (dir == 0) begin
            {ab_en_n, ab_le_n, ab_oe_n} = r[19:17];
            {ba_en_n, ba_le_n, ba_oe_n} = 3'b111;
            a_in = r[16:9];
            b_in = 8'h99;
        end else begin
            {ba_en_n, ba_le_n, ba_oe_n} = r[19:17];
            {ab_en_n, ab_le_n, ab_oe_n} = 3'b111;
            b_in = r[16:9];
            a_in = 8'h66;
        end
        #1;
        if (dir == 0) begin
            check($sformatf("R7 A-to-B row %0d", idx), {b_oe, b_out}, r[8:0]);
            check($sformatf("R8 idle B-to-A row %0d", idx), {a_oe, a_out}, 9'h000);
        end else begin
            check($sformatf("R8 B-to-A row %0d", idx), {a_oe, a_out}, r[8:0]);
            check($sformatf("R8 idle A-to-B row %0d", idx), {b_oe, b_out}, 9'h000);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset flags", {a_oe, b_oe, 7'h0}, 9'h000);
        rst_n = 1'b1;
        {ab_en_n, ab_le_n, ab_oe_n} = 3'b010;
        {ba_en_n, ba_le_n, ba_oe_n} = 3'b010;
        #1;
        check("R1 A-to-B cleared", {b_oe, b_out}, {1'b1, 8'h00});
        check("R1 B-to-A cleared", {a_oe, a_out}, {1'b1, 8'h00});

        for (int dir = 0; dir < 2; dir++)
            for (int i = 0; i < 12; i++)
                run_row(dir, ROWS[i], i);

        // R8: store distinct words in both, then confirm neither disturbs the other.
        @(negedge clk);
        {ab_en_n, ab_le_n, ab_oe_n} = 3'b001; a_in = 8'h4E;
        {ba_en_n, ba_le_n, ba_oe_n} = 3'b001; b_in = 8'hB1;
        @(negedge clk);
        {ab_en_n, ab_le_n, ab_oe_n} = 3'b010; a_in = 8'h00;
        {ba_en_n, ba_le_n, ba_oe_n} = 3'b010; b_in = 8'hFF;
        #1;
        check("R8 A-to-B own word", {b_oe, b_out}, {1'b1, 8'h4E});
        check("R8 B-to-A own word", {a_oe, a_out}, {1'b1, 8'hB1});

        // R1: reset in the middle with capture open, word must clear.
        @(negedge clk);
        rst_n = 1'b0;
        {ab_en_n, ab_le_n, ab_oe_n} = 3'b000; a_in = 8'hF0;
        #1;
        check("R1 flag low in reset", {b_oe, 8'h00}, 9'h000);
        check("R9 data zero in reset", {1'b0, b_out}, 9'h000);
        @(negedge clk);
        rst_n = 1'b1;
        {ab_en_n, ab_le_n, ab_oe_n} = 3'b010;
        {ba_en_n, ba_le_n, ba_oe_n} = 3'b010;
        #1;
        check("R1 A-to-B word cleared", {b_oe, b_out}, {1'b1, 8'h00});
        check("R1 B-to-A word cleared", {a_oe, a_out}, {1'b1, 8'h00});
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule